// File: doc/BRIEF.md
# Port Option and Pin-Function Controller

This block holds the option byte that an 8051-style controller uses to reshape a few of its pins, together with the port 4 output latch whose bits can take over two bus-strobe pins. The CPU reaches both through a byte-wide special-function-register bus with separate write and read strobes. It also has a single-bit write path for the bit-addressable port 4.

The option byte controls four things. It turns on the weak pull-ups of port 0. It selects strong sink drive on each of the upper four port 3 pins, one bit per pin. It also picks, separately for the address-latch strobe pin and the program-fetch strobe pin, whether the pin carries the core's strobe or acts as a general-purpose port 4 bit.

An ALE-off input from an auxiliary register can silence the address-latch strobe without freeing the pin. A pin changes function, and the ALE-off setting takes effect, only at a clock edge where the core strobe is at its idle level. A strobe pulse that has already started is never cut short.

Top module: `pinopt_ctrl`

## Requirements
- R1: The option byte is at address 86H. A byte write stores bits 6..0. A read there returns them with bit 7 always 0. Writes to other addresses leave it unchanged, and reads of unmapped addresses return 00H.
- R2: Synchronous reset has three effects. It clears the option byte and sets every port 4 latch bit to 1. It also returns both strobe pins to strobe mode with the ALE gate open.
- R3: Option bit 0 drives every port 0 pull-up enable output.
- R4: Option bits 1..4 drive the high-drive enables of P3.4..P3.7 one-to-one and independently, so bit 1 maps to hidrv bit 0.
- R5: In strobe mode with ALE-off clear, the ALE pin equals the core ALE strobe. The pin is never high unless the core ALE is high.
- R6: Once ALE-off has been taken at an edge with core ALE low, the ALE pin stays low for all later pulses.
- R7: With option bit 5 active, ale_pad_gpio is 1 and the ALE pin equals port 4 latch bit 5, whatever the core ALE does.
- R8: A new function selection or ALE-off value takes effect only at a clock edge where the core strobe is idle. Idle is low for ALE and high for PSEN. The earliest such edge is the one after the write edge, so a pulse in progress completes at full length.
- R9: Without option bit 6 active, the PSEN pin equals the core PSEN. With option bit 6 active, psen_pad_gpio is 1 and the pin equals port 4 latch bit 6.
- R10: Port 4 is at D8H. A byte write stores bits 0..3, 5 and 6. A read returns those latch bits, with bits 4 and 7 reading 1.
- R11: A bit write to bit address D8H..DFH updates latch bit (address bits 2..0). Indices 4 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | Byte register address for write and read |
| sfr_wr | input | 1 | Byte write strobe |
| sfr_wdata | input | 8 | Byte write data |
| sfr_rdata | output | 8 | Read data for sfr_addr |
| bit_wr | input | 1 | Single-bit write strobe |
| bit_addr | input | 8 | Bit address for the single-bit write |
| bit_val | input | 1 | Value for the single-bit write |
| core_ale | input | 1 | Address-latch strobe from the core, idle low |
| core_psen | input | 1 | Program-fetch strobe from the core, active low, idle high |
| aux_ale_off | input | 1 | ALE-off bit from the auxiliary register |
| p0_pullup_en | output | P0_WIDTH | Weak pull-up enable per port 0 pin |
| p3_hidrv | output | 4 | High-drive enables for P3.4..P3.7 |
| p4_low_out | output | 4 | Port 4 latch bits 0..3 to the pads |
| ale_pin | output | 1 | Level driven on the ALE pad |
| ale_pad_gpio | output | 1 | ALE pad is in general-purpose mode |
| psen_pin | output | 1 | Level driven on the PSEN pad |
| psen_pad_gpio | output | 1 | PSEN pad is in general-purpose mode |

## Verification
The hardest case to reach is a function switch requested while a strobe pulse is high. Without it, the rule against truncated pulses is never tested. The stimulus raises core ALE and issues the option write in the same cycle. It then checks that the pin stays high for the rest of the pulse, and that the pad becomes general-purpose only at the first edge after ALE falls. The bench clears latch bit 5 beforehand so the handover shows as a clean drop to 0. The ALE-off input is raised while ALE is idle, and pulses are counted before and after it.

// File: rtl/pinopt_pkg.sv
package pinopt_pkg;

    localparam logic [7:0] OPT_ADDR     = 8'h86;
    localparam logic [7:0] P4_ADDR      = 8'hD8;
    localparam logic [7:0] P4_IMPL_MASK = 8'b0110_1111;
    localparam int         P4_ALE_BIT   = 5;
    localparam int         P4_PSEN_BIT  = 6;
    localparam int         HIDRV_W      = 4;

    typedef struct packed {
        logic               spare;
        logic               psen_gpio;
        logic               ale_gpio;
        logic [HIDRV_W-1:0] hidrv;
        logic               p0_pullup;
    } opt_reg_t;

    function automatic opt_reg_t opt_from_byte(input logic [7:0] b);
        opt_reg_t r;
        r       = opt_reg_t'(b);
        r.spare = 1'b0;
        return r;
    endfunction

    function automatic logic [7:0] p4_merge(input logic [7:0] old_lat,
                                            input logic [7:0] new_dat);
        return (new_dat & P4_IMPL_MASK) | (old_lat & ~P4_IMPL_MASK);
    endfunction

    function automatic logic [7:0] p4_readback(input logic [7:0] lat);
        return (lat & P4_IMPL_MASK) | ~P4_IMPL_MASK;
    endfunction

    function automatic logic is_p4_bit_addr(input logic [7:0] a);
        return a[7:3] == P4_ADDR[7:3];
    endfunction

endpackage

// File: rtl/pinopt_regs.sv
module pinopt_regs
    import pinopt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] sfr_addr,
    input  logic       sfr_wr,
    input  logic [7:0] sfr_wdata,
    input  logic       bit_wr,
    input  logic [7:0] bit_addr,
    input  logic       bit_val,
    output opt_reg_t   opt_q,
    output logic [7:0] p4_lat_q,
    output logic [7:0] sfr_rdata
);

    logic       opt_hit;
    logic       p4_hit;
    logic       bit_hit;
    logic [2:0] bit_idx;
    logic [7:0] bit_next;

    assign opt_hit = sfr_wr && (sfr_addr == OPT_ADDR);
    assign p4_hit  = sfr_wr && (sfr_addr == P4_ADDR);
    assign bit_idx = bit_addr[2:0];
    assign bit_hit = bit_wr && is_p4_bit_addr(bit_addr) && P4_IMPL_MASK[bit_idx];

    always_comb begin
        bit_next          = p4_lat_q;
        bit_next[bit_idx] = bit_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            opt_q <= '0;
        end else if (opt_hit) begin
            opt_q <= opt_from_byte(sfr_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p4_lat_q <= 8'hFF;
        end else if (p4_hit) begin
            p4_lat_q <= p4_merge(p4_lat_q, sfr_wdata);
        end else if (bit_hit) begin
            p4_lat_q <= bit_next;
        end
    end

    always_comb begin
        unique case (sfr_addr)
            OPT_ADDR: sfr_rdata = 8'(opt_q);
            P4_ADDR:  sfr_rdata = p4_readback(p4_lat_q);
            default:  sfr_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/pinopt_strobe_mux.sv
module pinopt_strobe_mux #(
    parameter logic IDLE_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_in,
    input  logic gpio_req,
    input  logic off_req,
    input  logic gpio_val,
    output logic pin_out,
    output logic gpio_mode
);

    logic sel_q;
    logic off_q;
    logic at_idle;

    assign at_idle = (strobe_in == IDLE_LEVEL);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
            off_q <= 1'b0;
        end else if (at_idle) begin
            sel_q <= gpio_req;
            off_q <= off_req;
        end
    end

    always_comb begin
        if (sel_q) begin
            pin_out = gpio_val;
        end else if (off_q) begin
            pin_out = IDLE_LEVEL;
        end else begin
            pin_out = strobe_in;
        end
    end

    assign gpio_mode = sel_q;

endmodule

// File: rtl/pinopt_ctrl.sv
module pinopt_ctrl
    import pinopt_pkg::*;
#(
    parameter int P0_WIDTH = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [7:0]          sfr_addr,
    input  logic                sfr_wr,
    input  logic [7:0]          sfr_wdata,
    output logic [7:0]          sfr_rdata,
    input  logic                bit_wr,
    input  logic [7:0]          bit_addr,
    input  logic                bit_val,
    input  logic                core_ale,
    input  logic                core_psen,
    input  logic                aux_ale_off,
    output logic [P0_WIDTH-1:0] p0_pullup_en,
    output logic [3:0]          p3_hidrv,
    output logic [3:0]          p4_low_out,
    output logic                ale_pin,
    output logic                ale_pad_gpio,
    output logic                psen_pin,
    output logic                psen_pad_gpio
);

    opt_reg_t   opt_q;
    logic [7:0] p4_lat_q;

    pinopt_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .sfr_addr  (sfr_addr),
        .sfr_wr    (sfr_wr),
        .sfr_wdata (sfr_wdata),
        .bit_wr    (bit_wr),
        .bit_addr  (bit_addr),
        .bit_val   (bit_val),
        .opt_q     (opt_q),
        .p4_lat_q  (p4_lat_q),
        .sfr_rdata (sfr_rdata)
    );

    generate
        for (genvar i = 0; i < P0_WIDTH; i++) begin : g_p0_pull
            assign p0_pullup_en[i] = opt_q.p0_pullup;
        end
        for (genvar j = 0; j < HIDRV_W; j++) begin : g_p3_drive
            assign p3_hidrv[j] = opt_q.hidrv[j];
        end
    endgenerate

    assign p4_low_out = p4_lat_q[3:0];

    pinopt_strobe_mux #(.IDLE_LEVEL(1'b0)) u_ale_mux (
        .clk       (clk),
        .rst       (rst),
        .strobe_in (core_ale),
        .gpio_req  (opt_q.ale_gpio),
        .off_req   (aux_ale_off),
        .gpio_val  (p4_lat_q[P4_ALE_BIT]),
        .pin_out   (ale_pin),
        .gpio_mode (ale_pad_gpio)
    );

    pinopt_strobe_mux #(.IDLE_LEVEL(1'b1)) u_psen_mux (
        .clk       (clk),
        .rst       (rst),
        .strobe_in (core_psen),
        .gpio_req  (opt_q.psen_gpio),
        .off_req   (1'b0),
        .gpio_val  (p4_lat_q[P4_PSEN_BIT]),
        .pin_out   (psen_pin),
        .gpio_mode (psen_pad_gpio)
    );

endmodule

// File: rtl/pinopt_ctrl_chk.sv
module pinopt_ctrl_chk #(
    parameter int P0_WIDTH = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [7:0]          sfr_addr,
    input logic                sfr_wr,
    input logic [7:0]          sfr_wdata,
    input logic                core_ale,
    input logic                core_psen,
    input logic [P0_WIDTH-1:0] p0_pullup_en,
    input logic [3:0]          p3_hidrv,
    input logic                ale_pin,
    input logic                ale_pad_gpio,
    input logic                psen_pin,
    input logic                psen_pad_gpio
);

    assert_reset_clears_R2: assert property (@(posedge clk)
        rst |=> (p3_hidrv == 4'h0 && p0_pullup_en == '0 && !ale_pad_gpio && !psen_pad_gpio));

    assert_pullup_follows_R3: assert property (@(posedge clk) disable iff (rst)
        (sfr_wr && sfr_addr == 8'h86) |=>
            (p0_pullup_en == {P0_WIDTH{$past(sfr_wdata[0])}}));

    assert_hidrv_follows_R4: assert property (@(posedge clk) disable iff (rst)
        (sfr_wr && sfr_addr == 8'h86) |=> (p3_hidrv == $past(sfr_wdata[4:1])));

    assert_ale_only_in_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        (!ale_pad_gpio && ale_pin) |-> core_ale);

    assert_ale_switch_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!$stable(ale_pad_gpio) && !$past(rst)) |-> !$past(core_ale));

    assert_psen_switch_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!$stable(psen_pad_gpio) && !$past(rst)) |-> $past(core_psen));

    assert_psen_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        (!psen_pad_gpio) |-> (psen_pin == core_psen));

endmodule

bind pinopt_ctrl pinopt_ctrl_chk #(.P0_WIDTH(P0_WIDTH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .sfr_addr      (sfr_addr),
    .sfr_wr        (sfr_wr),
    .sfr_wdata     (sfr_wdata),
    .core_ale      (core_ale),
    .core_psen     (core_psen),
    .p0_pullup_en  (p0_pullup_en),
    .p3_hidrv      (p3_hidrv),
    .ale_pin       (ale_pin),
    .ale_pad_gpio  (ale_pad_gpio),
    .psen_pin      (psen_pin),
    .psen_pad_gpio (psen_pad_gpio)
);

// File: tb/tb_pinopt_ctrl.sv
module tb_pinopt_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] sfr_addr = 8'h00;
    logic       sfr_wr = 1'b0;
    logic [7:0] sfr_wdata = 8'h00;
    logic [7:0] sfr_rdata;
    logic       bit_wr = 1'b0;
    logic [7:0] bit_addr = 8'h00;
    logic       bit_val = 1'b0;
    logic       core_ale = 1'b0;
    logic       core_psen = 1'b1;
    logic       aux_ale_off = 1'b0;
    logic [7:0] p0_pullup_en;
    logic [3:0] p3_hidrv;
    logic [3:0] p4_low_out;
    logic       ale_pin, ale_pad_gpio, psen_pin, psen_pad_gpio;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    pinopt_ctrl dut (
        .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .bit_wr(bit_wr),
        .bit_addr(bit_addr), .bit_val(bit_val), .core_ale(core_ale),
        .core_psen(core_psen), .aux_ale_off(aux_ale_off),
        .p0_pullup_en(p0_pullup_en), .p3_hidrv(p3_hidrv),
        .p4_low_out(p4_low_out), .ale_pin(ale_pin),
        .ale_pad_gpio(ale_pad_gpio), .psen_pin(psen_pin),
        .psen_pad_gpio(psen_pad_gpio)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        core_ale = 1'b0; core_psen = 1'b1; aux_ale_off = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        @(negedge clk);
        sfr_wr = 1'b0;
    endtask

    task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
        sfr_addr = a;
        #1;
        d = sfr_rdata;
    endtask

    task automatic bit_write(input logic [7:0] a, input logic v);
        bit_addr = a; bit_val = v; bit_wr = 1'b1;
        @(negedge clk);
        bit_wr = 1'b0;
    endtask

    task automatic ale_train(input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            core_ale = 1'b1;
            #1;
            if (ale_pin) seen++;
            @(negedge clk);
            core_ale = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        do_reset();
        sfr_read(8'h86, d);
        check("R2 option byte after reset", d, 8'h00);
        sfr_read(8'hD8, d);
        check("R2 port4 after reset", d, 8'hFF);
        check("R2 pullups after reset", p0_pullup_en, 8'h00);
        check("R2 hidrv after reset", p3_hidrv, 4'h0);
        check("R2 ale gpio after reset", ale_pad_gpio, 1'b0);
    endtask

    task automatic t_option_byte();
        logic [7:0] d;
        do_reset();
        sfr_write(8'h86, 8'h9F);
        sfr_read(8'h86, d);
        check("R1 readback bit7 zero", d, 8'h1F);
        sfr_write(8'h87, 8'h00);
        sfr_read(8'h86, d);
        check("R1 other address ignored", d, 8'h1F);
        sfr_read(8'h87, d);
        check("R1 unmapped read zero", d, 8'h00);
        check("R3 pullups all on", p0_pullup_en, 8'hFF);
        check("R4 all hidrv on", p3_hidrv, 4'hF);
        sfr_write(8'h86, 8'h04);
        check("R3 pullups off", p0_pullup_en, 8'h00);
        check("R4 only P3.5 hidrv", p3_hidrv, 4'h2);
        sfr_write(8'h86, 8'h10);
        check("R4 only P3.7 hidrv", p3_hidrv, 4'h8);
    endtask

    task automatic t_ale_off();
        int n;
        do_reset();
        ale_train(4, n);
        check("R5 pulses pass in strobe mode", n, 4);
        aux_ale_off = 1'b1;
        @(negedge clk);
        ale_train(4, n);
        check("R6 pulses blocked by ale-off", n, 0);
        check("R6 not gpio", ale_pad_gpio, 1'b0);
    endtask

    task automatic t_ale_gpio();
        int n;
        do_reset();
        ale_train(3, n);
        check("R5 pulses before enable", n, 3);
        sfr_write(8'h86, 8'h20);
        @(negedge clk);
        check("R7 ale pad in gpio mode", ale_pad_gpio, 1'b1);
        check("R7 pin follows latch one", ale_pin, 1'b1);
        sfr_write(8'hD8, 8'h00);
        ale_train(3, n);
        check("R7 pulses gone, pin follows latch zero", n, 0);
        bit_write(8'hDD, 1'b1);
        check("R11 bit write sets latch5 on pin", ale_pin, 1'b1);
    endtask

    task automatic t_partial_pulse();
        do_reset();
        sfr_write(8'hD8, 8'h00);
        core_ale = 1'b1;
        sfr_write(8'h86, 8'h20);
        check("R8 pulse continues after write", ale_pin, 1'b1);
        check("R8 still strobe mode mid-pulse", ale_pad_gpio, 1'b0);
        core_ale = 1'b0;
        #1;
        check("R8 pulse ends normally", ale_pin, 1'b0);
        @(negedge clk);
        check("R8 gpio after idle edge", ale_pad_gpio, 1'b1);
        check("R7 pin equals latch5 zero", ale_pin, 1'b0);
        sfr_write(8'hD8, 8'h20);
        check("R7 pin equals latch5 one", ale_pin, 1'b1);
    endtask

    task automatic t_psen();
        do_reset();
        core_psen = 1'b0;
        #1;
        check("R9 psen pin passes strobe low", psen_pin, 1'b0);
        core_psen = 1'b1;
        sfr_write(8'hD8, 8'h00);
        sfr_write(8'h86, 8'h40);
        @(negedge clk);
        check("R9 psen pad gpio", psen_pad_gpio, 1'b1);
        check("R9 psen pin equals latch6 zero", psen_pin, 1'b0);
        core_psen = 1'b0;
        #1;
        check("R9 psen ignores strobe in gpio", psen_pin, 1'b0);
        core_psen = 1'b1;
        bit_write(8'hDE, 1'b1);
        check("R9 psen pin equals latch6 one", psen_pin, 1'b1);
    endtask

    task automatic t_port4();
        logic [7:0] d;
        do_reset();
        sfr_write(8'hD8, 8'h00);
        sfr_read(8'hD8, d);
        check("R10 unused bits read one", d, 8'h90);
        check("R10 low nibble to pads", p4_low_out, 4'h0);
        sfr_write(8'hD8, 8'h6A);
        sfr_read(8'hD8, d);
        check("R10 pattern readback", d, 8'hFA);
        bit_write(8'hDC, 1'b0);
        bit_write(8'hDF, 1'b0);
        sfr_read(8'hD8, d);
        check("R11 unimplemented bit writes ignored", d, 8'hFA);
        bit_write(8'hD9, 1'b0);
        bit_write(8'hD8, 1'b1);
        sfr_read(8'hD8, d);
        check("R11 bit writes to 1 and 0", d, 8'hF9);
        bit_write(8'hE1, 1'b0);
        sfr_read(8'hD8, d);
        check("R11 bit address outside port ignored", d, 8'hF9);
        sfr_write(8'h86, 8'h7F);
        do_reset();
        sfr_read(8'h86, d);
        check("R2 reset after writes clears option", d, 8'h00);
        sfr_read(8'hD8, d);
        check("R2 reset after writes sets latch", d, 8'hFF);
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_option_byte();
        t_ale_off();
        t_ale_gpio();
        t_partial_pulse();
        t_psen();
        t_port4();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule